// File: doc/BRIEF.md
# Mailbox Command Requester Engine

This block is a host-side sequencer that carries out one command exchange with a service processor through a shared bank of mailbox registers. A request of four 64-bit words is presented together with two 4-bit selects. One select names the request registers to be written. The other names the response registers to be read back. On `start` the engine inserts its own 16-bit sequence number into request word 0. It then writes the selected request registers and raises the message-waiting bit of the service doorbell through its set alias. After that it keeps reading the host doorbell until the response-waiting bit appears or a cycle limit runs out.

When the response is flagged, the engine reads the selected response registers into holding words. It checks the primary status and the echoed sequence, class and command fields against the request, and then clears the response-waiting bit through the host doorbell clear alias. All register traffic goes over a simple request/acknowledge read/write bus. The result is a one-cycle `done` pulse with the four response words and three error flags, all of which hold until the next command. Each command selects either a short or a long limit. The limits are given in milliseconds and converted to cycles from the clock frequency parameter.

Top module: `mbx_req_engine`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and the three error flags are 0. Response word 0 (`rsp_words[63:0]`) is all ones and words 1 to 3 are zero.
- R2: For each set bit i of `wr_sel`, in ascending i, one write goes to address REQ_BASE+i (default 0x00+i) with request word i (`req_words[64i+63:64i]`). Word 0 is sent with bits 31:16 replaced by the command's sequence number. Unselected request registers are never written.
- R3: After the request writes, exactly one write goes to the service doorbell set address (default 0x10) with data 0x8000_0000_0000_0000.
- R4: After that write, the engine reads the host doorbell address (default 0x18) repeatedly. It stops at the first read whose bit 63 is 1, so it issues one poll per unanswered read plus the final one.
- R5: For each set bit i of `rd_sel`, in ascending i, one read goes to RSP_BASE+i (default 0x04+i) and its data lands in response word i. Each new command first presets word 0 to all ones and words 1 to 3 to zero, and unread words keep those presets.
- R6: After the response reads, one write of 0x7FFF_FFFF_FFFF_FFFF goes to the host doorbell clear address (default 0x19), and then `done` pulses.
- R7: Cycles are counted in the polling phase, with the first polling cycle numbered 0. The limit is CLK_KHZ*SHORT_MS when `long_to`=0 and CLK_KHZ*LONG_MS when `long_to`=1. If a poll read returns bit 63 = 0 in a cycle whose count has reached the limit, the command ends with `err_timeout`=1 and `err_status`=`err_echo`=0, with no response reads and no clear write.
- R8: `err_status` is 1 when the primary status in response word 0 (bits 63:48) is nonzero. Code 0x0000 means success.
- R9: `err_echo` is 1 when any of the following differs from the request: response word 0 bits 31:16 (sequence), bits 15:8 (class) or bits 7:0 (command).
- R10: The sequence counter starts at 0 after reset and is used by the first command. It advances by one for every accepted command, modulo 2^16.
- R11: A `start` while `busy` is 1 is ignored. The bus traffic and result of the running command are unchanged, and no sequence number is consumed.
- R12: `done` is high for exactly one cycle. The response words and error flags hold their values until the next accepted `start`.
- R13: Once `bus_req` is high without `bus_ack`, it stays high on the next cycle with the same address, direction and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command when idle |
| long_to | input | 1 | 1 selects the long limit, 0 the short one |
| wr_sel | input | 4 | Request registers to write, bit i for register i |
| rd_sel | input | 4 | Response registers to read, bit i for register i |
| req_words | input | 256 | Request words, word i at bits 64i+63:64i |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Response flag not seen within the limit |
| err_status | output | 1 | Nonzero primary status |
| err_echo | output | 1 | Echoed sequence, class or command mismatch |
| rsp_words | output | 256 | Response holding words, word i at bits 64i+63:64i |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access complete; read data valid this cycle |
| bus_rdata | input | 64 | Read data |

## Verification
The bench's bus responder acknowledges every access in the second cycle of the request. As a result, the k-th poll (counting from 0) completes when the polling counter is 1+2k. The timeout therefore falls exactly when 2·delay−1 reaches the limit, and the bench probes both sides of that boundary for each limit. The error flags and response words are registered on the same edge that raises `done`. The bench waits at falling edges for `done`, reads every result there, and one falling edge later confirms that `done` has dropped while the results held. The bus trace is logged at the responder and compared entry by entry with a list built from the selects once the command is complete, so no check depends on an intermediate cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned NREG   = 4;
   localparam int unsigned WORD_W = 64;
   localparam int unsigned IDX_W  = $clog2(NREG);

   localparam logic [WORD_W-1:0] MSG_BIT     = 64'h8000_0000_0000_0000;
   localparam logic [WORD_W-1:0] CLR_MASK    = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam logic [WORD_W-1:0] RSP_PRESET0 = {WORD_W{1'b1}};

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREQ,
      ST_RING,
      ST_POLL,
      ST_RRSP,
      ST_CLEAR,
      ST_DONE
   } mbx_state_e;
endpackage

// File: rtl/mbx_lsb_pick.sv
module mbx_lsb_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   initial begin : p_cfg
      assert (N >= 2) else $error("mbx_lsb_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign any = |vec;
endmodule

// File: rtl/mbx_timer.sv
module mbx_timer #(
   parameter int unsigned     CNT_W     = 16,
   parameter longint unsigned SHORT_LIM = 100,
   parameter longint unsigned LONG_LIM  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_long,
   output logic expired
);
   localparam logic [CNT_W-1:0] S_LIM = CNT_W'(SHORT_LIM);
   localparam logic [CNT_W-1:0] L_LIM = CNT_W'(LONG_LIM);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim = sel_long ? L_LIM : S_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt < lim)  cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= lim);

   AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= lim); // R7
   AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt <= 1); // R7
endmodule

// File: rtl/mbx_rsp_check.sv
module mbx_rsp_check (
   input  logic [63:0] rsp_w0,
   input  logic [15:0] exp_seq,
   input  logic [7:0]  exp_cls,
   input  logic [7:0]  exp_cmd,
   output logic        status_bad,
   output logic        echo_bad
);
   logic [15:0] prim;
   logic [15:0] seq_r;
   logic [7:0]  cls_r;
   logic [7:0]  cmd_r;

   assign prim  = rsp_w0[63:48];
   assign seq_r = rsp_w0[31:16];
   assign cls_r = rsp_w0[15:8];
   assign cmd_r = rsp_w0[7:0];

   assign status_bad = (prim != 16'h0000);
   assign echo_bad   = (seq_r != exp_seq) || (cls_r != exp_cls) || (cmd_r != exp_cmd);
endmodule

// File: rtl/mbx_req_engine.sv
module mbx_req_engine
   import mbx_pkg::*;
#(
   parameter int unsigned     ADDR_W      = 8,
   parameter int unsigned     REQ_BASE    = 'h00,
   parameter int unsigned     RSP_BASE    = 'h04,
   parameter int unsigned     SVC_DB_SET  = 'h10,
   parameter int unsigned     HOST_DB_RD  = 'h18,
   parameter int unsigned     HOST_DB_CLR = 'h19,
   parameter longint unsigned CLK_KHZ     = 100000,
   parameter longint unsigned SHORT_MS    = 100,
   parameter longint unsigned LONG_MS     = 30000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     long_to,
   input  logic [NREG-1:0]          wr_sel,
   input  logic [NREG-1:0]          rd_sel,
   input  logic [NREG*WORD_W-1:0]   req_words,
   output logic                     busy,
   output logic                     done,
   output logic                     err_timeout,
   output logic                     err_status,
   output logic                     err_echo,
   output logic [NREG*WORD_W-1:0]   rsp_words,
   output logic                     bus_req,
   output logic                     bus_we,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [WORD_W-1:0]        bus_wdata,
   input  logic                     bus_ack,
   input  logic [WORD_W-1:0]        bus_rdata
);
   localparam longint unsigned SHORT_LIM = CLK_KHZ * SHORT_MS;
   localparam longint unsigned LONG_LIM  = CLK_KHZ * LONG_MS;
   localparam int unsigned     TMR_W     = $clog2(LONG_LIM + 1);

   initial begin : p_cfg
      assert (LONG_LIM > SHORT_LIM && SHORT_LIM > 0)
         else $error("mbx_req_engine: limits must satisfy 0 < short < long");
      assert (HOST_DB_CLR < (1 << ADDR_W) && SVC_DB_SET < (1 << ADDR_W))
         else $error("mbx_req_engine: addresses exceed ADDR_W");
      assert (REQ_BASE + NREG <= (1 << ADDR_W) && RSP_BASE + NREG <= (1 << ADDR_W))
         else $error("mbx_req_engine: register windows exceed ADDR_W");
   end

   mbx_state_e                    st;
   logic [NREG-1:0][WORD_W-1:0]   req_q;
   logic [NREG-1:0]               wr_sel_q;
   logic [NREG-1:0]               rd_sel_q;
   logic                          long_q;
   logic [NREG-1:0]               pend;
   logic [15:0]                   seq_q;
   logic [IDX_W-1:0]              pick_idx;
   logic                          pick_any;
   logic                          tmr_expired;
   logic                          status_bad;
   logic                          echo_bad;
   logic                          accept;

   assign accept = (st == ST_IDLE) && start;
   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_DONE);

   mbx_lsb_pick #(.N(NREG), .IW(IDX_W)) u_pick (
      .vec (pend),
      .idx (pick_idx),
      .any (pick_any)
   );

   mbx_timer #(.CNT_W(TMR_W), .SHORT_LIM(SHORT_LIM), .LONG_LIM(LONG_LIM)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (st == ST_POLL),
      .sel_long (long_q),
      .expired  (tmr_expired)
   );

   mbx_rsp_check u_chk (
      .rsp_w0     (rsp_words[WORD_W-1:0]),
      .exp_seq    (req_q[0][31:16]),
      .exp_cls    (req_q[0][15:8]),
      .exp_cmd    (req_q[0][7:0]),
      .status_bad (status_bad),
      .echo_bad   (echo_bad)
   );

   // Bus command decode: one access per state, held until acknowledged.
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (st)
         ST_WREQ: if (pick_any) begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = ADDR_W'(REQ_BASE) + ADDR_W'(pick_idx);
            bus_wdata = req_q[pick_idx];
         end
         ST_RING: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = ADDR_W'(SVC_DB_SET);
            bus_wdata = MSG_BIT;
         end
         ST_POLL: begin
            bus_req   = 1'b1;
            bus_addr  = ADDR_W'(HOST_DB_RD);
         end
         ST_RRSP: if (pick_any) begin
            bus_req   = 1'b1;
            bus_addr  = ADDR_W'(RSP_BASE) + ADDR_W'(pick_idx);
         end
         ST_CLEAR: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = ADDR_W'(HOST_DB_CLR);
            bus_wdata = CLR_MASK;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         req_q       <= '0;
         wr_sel_q    <= '0;
         rd_sel_q    <= '0;
         long_q      <= 1'b0;
         pend        <= '0;
         seq_q       <= '0;
         err_timeout <= 1'b0;
         err_status  <= 1'b0;
         err_echo    <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               req_q            <= req_words;
               req_q[0][31:16]  <= seq_q;
               wr_sel_q         <= wr_sel;
               rd_sel_q         <= rd_sel;
               long_q           <= long_to;
               pend             <= wr_sel;
               seq_q            <= seq_q + 16'd1;
               err_timeout      <= 1'b0;
               err_status       <= 1'b0;
               err_echo         <= 1'b0;
               st               <= ST_WREQ;
            end
            ST_WREQ: begin
               if (!pick_any)    st <= ST_RING;
               else if (bus_ack) pend[pick_idx] <= 1'b0;
            end
            ST_RING: if (bus_ack) st <= ST_POLL;
            ST_POLL: if (bus_ack) begin
               if (bus_rdata[WORD_W-1]) begin
                  pend <= rd_sel_q;
                  st   <= ST_RRSP;
               end else if (tmr_expired) begin
                  err_timeout <= 1'b1;
                  st          <= ST_DONE;
               end
            end
            ST_RRSP: begin
               if (!pick_any)    st <= ST_CLEAR;
               else if (bus_ack) pend[pick_idx] <= 1'b0;
            end
            ST_CLEAR: if (bus_ack) begin
               err_status <= status_bad;
               err_echo   <= echo_bad;
               st         <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Response holding words, each preset on command acceptance.
   for (genvar g = 0; g < NREG; g++) begin : g_hold
      localparam logic [WORD_W-1:0] PRESET = (g == 0) ? RSP_PRESET0 : {WORD_W{1'b0}};
      logic [WORD_W-1:0] held;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      held <= PRESET;
         else if (accept) held <= PRESET;
         else if (st == ST_RRSP && bus_ack && pick_any && pick_idx == IDX_W'(g))
            held <= bus_rdata;
      end
      assign rsp_words[g*WORD_W +: WORD_W] = held;
   end

   logic [ADDR_W-1:0] wr_off;
   logic [ADDR_W-1:0] rd_off;
   assign wr_off = bus_addr - ADDR_W'(REQ_BASE);
   assign rd_off = bus_addr - ADDR_W'(RSP_BASE);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R13
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && wr_off < ADDR_W'(NREG) |-> wr_sel_q[wr_off[IDX_W-1:0]]); // R2
   AST_RD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && rd_off < ADDR_W'(NREG) |-> rd_sel_q[rd_off[IDX_W-1:0]]); // R5
   AST_TO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done && err_timeout |-> !err_status && !err_echo); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(seq_q)); // R11
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> seq_q == $past(seq_q) + 16'd1); // R10
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(err_timeout) && $stable(err_status) && $stable(err_echo)); // R12
endmodule

// File: tb/tb_mbx_req_engine.sv
module tb_mbx_req_engine;
   localparam int CLK_PERIOD = 10;
   localparam int A_SVC  = 'h10;
   localparam int A_HRD  = 'h18;
   localparam int A_HCLR = 'h19;
   localparam int S_LIM  = 100;
   localparam int L_LIM  = 300;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         long_to = 1'b0;
   logic [3:0]   wr_sel = '0;
   logic [3:0]   rd_sel = '0;
   logic [255:0] req_words = '0;
   logic         busy, done, err_timeout, err_status, err_echo;
   logic [255:0] rsp_words;
   logic         bus_req, bus_we;
   logic [7:0]   bus_addr;
   logic [63:0]  bus_wdata;
   logic         bus_ack;
   logic [63:0]  bus_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_req_engine #(.CLK_KHZ(1), .SHORT_MS(100), .LONG_MS(300)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .long_to(long_to),
      .wr_sel(wr_sel), .rd_sel(rd_sel), .req_words(req_words),
      .busy(busy), .done(done), .err_timeout(err_timeout),
      .err_status(err_status), .err_echo(err_echo), .rsp_words(rsp_words),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   int exp_seq = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // ---------------- bus responder / service-processor model ----------------
   int unsigned  poll_delay = 0;
   logic [63:0]  rsp_prep [4];
   logic         ack_q = 1'b0;
   logic [63:0]  rdata_q = '0;
   bit           armed = 0;
   int unsigned  wait_n = 0;
   int           n_poll = 0;
   int           hold_err = 0;
   logic         prev_req = 1'b0;
   logic         prev_ack = 1'b0;
   logic         prev_we = 1'b0;
   logic [7:0]   prev_addr = '0;
   logic [63:0]  prev_wdata = '0;
   int           lg_n = 0;
   int           lg_addr [4096];
   bit           lg_we   [4096];
   logic [63:0]  lg_data [4096];

   assign bus_ack   = ack_q;
   assign bus_rdata = rdata_q;

   always @(posedge clk) begin
      if (rst_n) begin
         if (prev_req && !prev_ack &&
             !(bus_req && bus_addr == prev_addr && bus_we == prev_we && bus_wdata == prev_wdata))
            hold_err <= hold_err + 1;
         prev_req   <= bus_req;
         prev_ack   <= ack_q;
         prev_we    <= bus_we;
         prev_addr  <= bus_addr;
         prev_wdata <= bus_wdata;
         if (bus_req && !ack_q) begin
            ack_q   <= 1'b1;
            rdata_q <= '0;
            if (bus_we) begin
               lg_addr[lg_n] <= int'(bus_addr);
               lg_we[lg_n]   <= 1'b1;
               lg_data[lg_n] <= bus_wdata;
               lg_n          <= lg_n + 1;
               if (int'(bus_addr) == A_SVC && bus_wdata[63]) begin
                  armed  <= 1;
                  wait_n <= poll_delay;
               end
               if (int'(bus_addr) == A_HCLR && !bus_wdata[63]) armed <= 0;
            end else if (int'(bus_addr) == A_HRD) begin
               n_poll <= n_poll + 1;
               if (armed && wait_n == 0) rdata_q <= 64'h8000_0000_0000_0000;
               else if (armed)           wait_n  <= wait_n - 1;
            end else begin
               lg_addr[lg_n] <= int'(bus_addr);
               lg_we[lg_n]   <= 1'b0;
               lg_data[lg_n] <= '0;
               lg_n          <= lg_n + 1;
               if (bus_addr >= 8'h04 && bus_addr <= 8'h07) rdata_q <= rsp_prep[bus_addr[1:0]];
            end
         end else begin
            ack_q <= 1'b0;
         end
      end
   end

   function automatic string tag_of(input int a);
      if (a < 4)        return "R2";
      else if (a < 8)   return "R5";
      else if (a == A_SVC) return "R3";
      else              return "R6";
   endfunction

   // ---------------- one command with full checking ----------------
   task automatic run_cmd(input logic [3:0] ws, input logic [3:0] rs, input bit lt,
                          input logic [255:0] rq, input int unsigned pd,
                          input logic [15:0] prim, input bit bad_echo, input bit poke);
      logic [15:0] seq;
      logic [63:0] w0;
      logic [63:0] exp_rsp [4];
      int          e_addr [12];
      bit          e_we   [12];
      logic [63:0] e_data [12];
      int          ne;
      int          base;
      int          poll_base;
      int          lim;
      bit          to;
      int          exp_polls;
      int          cyc;
      bit          f_to, f_st, f_ec;
      seq = exp_seq[15:0];
      lim = lt ? L_LIM : S_LIM;
      to  = (2 * int'(pd) - 1) >= lim;
      if (to) begin
         int k = 0;
         while (1 + 2 * k < lim) k++;
         exp_polls = k + 1;
      end else begin
         exp_polls = int'(pd) + 1;
      end
      rsp_prep[0] = {prim, 16'h00A5, bad_echo ? (seq ^ 16'h0001) : seq, rq[15:8], rq[7:0]};
      for (int i = 1; i < 4; i++) rsp_prep[i] = {$urandom, $urandom};
      ne = 0;
      for (int i = 0; i < 4; i++) if (ws[i]) begin
         e_addr[ne] = i; e_we[ne] = 1;
         e_data[ne] = (i == 0) ? {rq[63:32], seq, rq[15:0]} : rq[64*i +: 64];
         ne++;
      end
      e_addr[ne] = A_SVC; e_we[ne] = 1; e_data[ne] = 64'h8000_0000_0000_0000; ne++;
      if (!to) begin
         for (int i = 0; i < 4; i++) if (rs[i]) begin
            e_addr[ne] = 4 + i; e_we[ne] = 0; e_data[ne] = '0; ne++;
         end
         e_addr[ne] = A_HCLR; e_we[ne] = 1; e_data[ne] = 64'h7FFF_FFFF_FFFF_FFFF; ne++;
      end
      for (int i = 0; i < 4; i++)
         exp_rsp[i] = (!to && rs[i]) ? rsp_prep[i] : ((i == 0) ? {64{1'b1}} : 64'h0);

      @(negedge clk);
      poll_delay = pd;
      base       = lg_n;
      poll_base  = n_poll;
      wr_sel = ws; rd_sel = rs; long_to = lt; req_words = rq; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
      cyc = 0;
      while (!done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 2) begin
            start = 1'b1; req_words = ~rq; wr_sel = ~ws; rd_sel = ~rs; long_to = ~lt;
         end else if (poke && cyc == 3) begin
            start = 1'b0;
         end
      end
      chk(done == 1'b1, "R6 done reached", 64'(done), 64'd1);
      chk(lg_n - base == ne, poke ? "R11 access count" : "R2 access count",
          64'(lg_n - base), 64'(ne));
      for (int j = 0; j < ne && j < lg_n - base; j++) begin
         chk(lg_addr[base + j] == e_addr[j] && lg_we[base + j] == e_we[j] &&
             (!e_we[j] || lg_data[base + j] == e_data[j]),
             tag_of(e_addr[j]), lg_data[base + j], e_data[j]);
      end
      chk(n_poll - poll_base == exp_polls, "R4 poll count", 64'(n_poll - poll_base), 64'(exp_polls));
      chk(err_timeout == to, "R7 timeout flag", 64'(err_timeout), 64'(to));
      w0 = exp_rsp[0];
      chk(err_status == (!to && w0[63:48] != 0), "R8 status flag", 64'(err_status),
          64'(!to && w0[63:48] != 0));
      chk(err_echo == (!to && (w0[31:16] != seq || w0[15:8] != rq[15:8] || w0[7:0] != rq[7:0])),
          "R9 echo flag", 64'(err_echo),
          64'(!to && (w0[31:16] != seq || w0[15:8] != rq[15:8] || w0[7:0] != rq[7:0])));
      for (int i = 0; i < 4; i++)
         chk(rsp_words[64*i +: 64] == exp_rsp[i], "R5 response word", rsp_words[64*i +: 64], exp_rsp[i]);
      f_to = err_timeout; f_st = err_status; f_ec = err_echo;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R12 done single cycle", 64'(done), 64'd0);
      chk(err_timeout == f_to && err_status == f_st && err_echo == f_ec && rsp_words[63:0] == w0,
          "R12 results held", rsp_words[63:0], w0);
      exp_seq = (exp_seq + 1) % 65536;
   endtask

   function automatic logic [255:0] rnd_req();
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
      return r;
   endfunction

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=0", 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && done == 0 && bus_req == 0, "R1 idle outputs", {61'd0, busy, done, bus_req}, 64'd0);
      chk(err_timeout == 0 && err_status == 0 && err_echo == 0, "R1 flags",
          {61'd0, err_timeout, err_status, err_echo}, 64'd0);
      chk(rsp_words == {192'd0, {64{1'b1}}}, "R1 response presets", rsp_words[63:0], {64{1'b1}});
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && bus_req == 0, "R1 idle after release", {62'd0, busy, bus_req}, 64'd0);

      // directed corner cases
      run_cmd(4'hF, 4'hF, 0, rnd_req(), 0, 16'h0000, 0, 0);   // R10 first seq 0, full exchange
      run_cmd(4'h0, 4'h0, 0, rnd_req(), 2, 16'h0000, 0, 0);   // R5 presets stay, flags from preset
      run_cmd(4'h5, 4'hA, 1, rnd_req(), 3, 16'h0000, 0, 0);   // R2 R5 sparse selects
      run_cmd(4'h1, 4'h1, 0, rnd_req(), 1, 16'h0003, 0, 0);   // R8 sequence-error status
      run_cmd(4'h1, 4'h1, 0, rnd_req(), 1, 16'h00FE, 0, 0);   // R8 generic failure status
      run_cmd(4'h3, 4'h1, 0, rnd_req(), 0, 16'h0000, 1, 0);   // R9 echo mismatch
      run_cmd(4'h3, 4'h1, 0, rnd_req(), 50, 16'h0000, 0, 0);  // R7 last poll before short limit
      run_cmd(4'h3, 4'h1, 0, rnd_req(), 51, 16'h0000, 0, 0);  // R7 short timeout
      run_cmd(4'h3, 4'h1, 1, rnd_req(), 51, 16'h0000, 0, 0);  // R7 long limit tolerates it
      run_cmd(4'h3, 4'h1, 1, rnd_req(), 150, 16'h0000, 0, 0); // R7 last poll before long limit
      run_cmd(4'h3, 4'h1, 1, rnd_req(), 151, 16'h0000, 0, 0); // R7 long timeout
      run_cmd(4'h6, 4'h9, 0, rnd_req(), 6, 16'h0000, 0, 1);   // R11 start while busy
      run_cmd(4'h1, 4'h1, 0, rnd_req(), 0, 16'h0000, 0, 0);   // R11 R10 seq not consumed

      // constrained random
      for (int n = 0; n < 60; n++) begin
         logic [15:0] st;
         st = ($urandom % 4 == 0) ? 16'(($urandom % 5) + 1) : 16'h0000;
         run_cmd(4'($urandom), 4'($urandom), 1'($urandom), rnd_req(),
                 $urandom % 6, st, ($urandom % 5) == 0, 0);
      end

      chk(hold_err == 0, "R13 request held until ack", 64'(hold_err), 64'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule